// File: doc/BRIEF.md
# Counter Peripheral Host Register Interface

This block is the host-facing side of a three-channel programmable counter. A host reaches it through a shared 8-bit bidirectional data bus, a 2-bit address and three active-low strobes: chip select, read and write. Addresses 0 to 2 select a counter channel. Address 3 carries command bytes. These command bytes set how later byte accesses to a channel are split between the low and high halves of its 16-bit count.

The block holds a 16-bit count register for each channel, stored as two byte registers. It publishes all three loaded values on a flat output bus. Each channel's counting engine returns a 16-bit readback value, and the host reads this value back one byte at a time. A command can freeze a snapshot of one channel's readback value, so that a two-byte read sees one coherent value. All internal steering uses multiplexers. The only high-impedance driver is at the data pins. The strobes are assumed to be synchronous to the system clock, which samples them.

Top module: `cnt_host_regif`

## Requirements
- R1: The data pins are driven only while chip select and read are both low. At all other times they are high impedance, so a byte the host drives during a write is captured unchanged.
- R2: Read data is chosen from the address, the channel's access mode and its byte pointer, independent of the strobes. A read at address 3 returns 8'h00.
- R3: A write has effect only while chip select and write are both low. A write strobe with chip select high changes no count.
- R4: A write is committed exactly once per strobe assertion, on the first clock edge that samples it active, however long the strobe is held. The new count is visible on the count outputs after that edge.
- R5: A write to address 3 is a command byte. Bits 7:6 name the channel (3 names none). A nonzero mode in bits 5:4 becomes that channel's access mode: 01 low byte only, 10 high byte only, 11 low then high.
- R6: A write to address 0, 1 or 2 loads the addressed channel's low byte in mode 01 and its high byte in mode 10. In mode 11 it loads the byte the pointer selects.
- R7: Each channel has a byte pointer. A command byte naming the channel clears it to low. In mode 11 it toggles after each committed write and after each completed read. A read completes on the first clock edge that samples the strobe released.
- R8: A command byte with mode 00 captures the channel's 16-bit readback value if no snapshot is already held, and leaves the access mode unchanged. While a snapshot is held, reads return its bytes. The snapshot is released after one read in modes 01 and 10, and after the high-byte read in mode 11.
- R9: After reset every channel is in mode 11 with the pointer on the low byte, its count is zero and no snapshot is held.
- R10: Channel i's count appears on bits 16i+15 down to 16i of the count output bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the strobes |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register address: 0 to 2 for channels, 3 for command bytes |
| io_data | inout | 8 | Shared bidirectional data bus |
| rdback | input | 48 | Readback values from the counting engines, channel i at bits 16i+15:16i |
| ch_count | output | 48 | Loaded count values, channel i at bits 16i+15:16i |

## Verification
Read data is combinational from the address, mode, pointer and snapshot. The bench therefore samples the pins two nanoseconds after lowering the read strobe, within the same cycle. A write commits on the first rising edge with the strobe active. Count outputs are compared at the falling edge that follows, one half period later. Pointer and snapshot updates from a read land on the rising edge after the strobe is released. Each read task waits one further falling edge before returning, so the next access always sees the updated state. The bench's reference model is updated only at those same points.

// File: rtl/cnt_regif_pkg.sv
// Package: shared types and constants for the counter host register interface.
// Assumes byte-wide host bus and 16-bit counts.
package cnt_regif_pkg;

    // Access mode carried in bits 5:4 of a command byte
    typedef enum logic [1:0] {
        ACC_LATCH = 2'b00,
        ACC_LO    = 2'b01,
        ACC_HI    = 2'b10,
        ACC_LOHI  = 2'b11
    } acc_mode_e;

    localparam int BYTE_W   = 8;
    localparam int CNT_W    = 2 * BYTE_W;
    localparam int MODE_LSB = 4;
    localparam int SEL_LSB  = 6;

endpackage

// File: rtl/cnt_bus_strobe.sv
// Module: cnt_bus_strobe
// Turns the level strobes into single-cycle events. A write commit fires on the
// first clock edge that sees chip select and write low. A read completion fires on
// the first edge after an active read is released, and carries the read address.
// Assumes the strobes and address are synchronous to clk.
module cnt_bus_strobe #(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              wr_commit,
    output logic              rd_done,
    output logic [ADDR_W-1:0] rd_addr
);

    logic wr_act;
    logic rd_act;
    logic wr_seen_q;
    logic rd_seen_q;
    logic [ADDR_W-1:0] rd_addr_q;

    assign wr_act = !cs_n && !wr_n;
    assign rd_act = !cs_n && !rd_n;

    // Remember whether each strobe was active on the previous edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_seen_q <= 1'b0;
            rd_seen_q <= 1'b0;
        end else begin
            wr_seen_q <= wr_act;
            rd_seen_q <= rd_act;
        end
    end

    // Hold the address of the read in progress for its completion event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_addr_q <= '0;
        end else if (rd_act) begin
            rd_addr_q <= addr;
        end
    end

    assign wr_commit = wr_act && !wr_seen_q;
    assign rd_done   = rd_seen_q && !rd_act;
    assign rd_addr   = rd_addr_q;

    // R7: a read completion only follows a cycle in which a read was active
    p_done_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> $past(!cs_n && !rd_n));

    // R4: a commit never fires on two consecutive edges
    p_single_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |=> !wr_commit);

endmodule

// File: rtl/cnt_chan.sv
// Module: cnt_chan
// One counter channel's host-side state: access mode, byte pointer, low and high
// count bytes, and a readback snapshot. Produces the byte a read of this channel
// returns. Assumes the hit inputs are single-cycle events from cnt_bus_strobe.
module cnt_chan
    import cnt_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              wr_hit,
    input  logic              cw_hit,
    input  acc_mode_e         cw_mode,
    input  logic              rd_hit,
    input  logic [CNT_W-1:0]  rdback,
    output logic [CNT_W-1:0]  count,
    output logic [BYTE_W-1:0] rd_byte
);

    acc_mode_e         mode_q;
    logic              ptr_q;
    logic [BYTE_W-1:0] lo_q;
    logic [BYTE_W-1:0] hi_q;
    logic              held_q;
    logic [CNT_W-1:0]  snap_q;
    logic              latch_cmd;
    logic              lo_we;
    logic              hi_we;
    logic              step_ptr;
    logic              release_snap;
    logic [CNT_W-1:0]  src;

    assign latch_cmd    = cw_hit && (cw_mode == ACC_LATCH);
    assign lo_we        = wr_hit && ((mode_q == ACC_LO) || ((mode_q == ACC_LOHI) && !ptr_q));
    assign hi_we        = wr_hit && ((mode_q == ACC_HI) || ((mode_q == ACC_LOHI) && ptr_q));
    assign step_ptr     = (wr_hit || rd_hit) && (mode_q == ACC_LOHI);
    assign release_snap = rd_hit && held_q && ((mode_q != ACC_LOHI) || ptr_q);

    // Access mode: taken from command bytes that carry a nonzero mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= ACC_LOHI;
        end else if (cw_hit && !latch_cmd) begin
            mode_q <= cw_mode;
        end
    end

    // Byte pointer: cleared by a command, toggled per access in two-byte mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= 1'b0;
        end else if (cw_hit) begin
            ptr_q <= 1'b0;
        end else if (step_ptr) begin
            ptr_q <= !ptr_q;
        end
    end

    // Count bytes: loaded only from the host data bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (lo_we) lo_q <= wr_data;
            if (hi_we) hi_q <= wr_data;
        end
    end

    // Snapshot: captured by a latch command, released when fully read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= 1'b0;
            snap_q <= '0;
        end else if (latch_cmd && !held_q) begin
            held_q <= 1'b1;
            snap_q <= rdback;
        end else if (release_snap) begin
            held_q <= 1'b0;
        end
    end

    // Read byte: snapshot or live readback, half chosen by mode and pointer
    always_comb begin
        src = held_q ? snap_q : rdback;
        unique case (mode_q)
            ACC_LO:  rd_byte = src[BYTE_W-1:0];
            ACC_HI:  rd_byte = src[CNT_W-1:BYTE_W];
            default: rd_byte = ptr_q ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0];
        endcase
    end

    assign count = {hi_q, lo_q};

    // R7: a command naming this channel leaves the pointer on the low byte
    p_ptr_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cw_hit |=> !ptr_q);

    // R7: with no access and no command the pointer does not move
    p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(cw_hit || wr_hit || rd_hit) |=> $stable(ptr_q));

    // R3: the count only changes after a committed write to this channel
    p_count_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(count));

    // R8: a latch command with no snapshot held captures the readback value
    p_latch_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_cmd && !held_q) |=> (held_q && (snap_q == $past(rdback))));

    // R8: a latch command does not alter the access mode
    p_latch_mode_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        latch_cmd |=> $stable(mode_q));

endmodule

// File: rtl/cnt_rd_mux.sv
// Module: cnt_rd_mux
// Selects the read byte from the addressed channel. Addresses past the last
// channel return zero. Select depends on the address only, never on strobes.
module cnt_rd_mux #(
    parameter int NUM_CH = 3,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic [ADDR_W-1:0]        addr,
    input  logic [NUM_CH*BYTE_W-1:0] ch_bytes,
    output logic [BYTE_W-1:0]        rd_byte
);

    // Pick the addressed channel's byte, zero for the command address
    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr == ADDR_W'(i)) rd_byte = ch_bytes[i*BYTE_W +: BYTE_W];
        end
    end

endmodule

// File: rtl/cnt_host_regif.sv
// Module: cnt_host_regif
// Host register interface of a three-channel counter peripheral. Decodes the
// strobes and address into per-channel write, command and read events, holds the
// count bytes per channel, and drives read data onto the shared pins. The pin
// enable and the read data select are separate logic. Assumes synchronous strobes.
module cnt_host_regif
    import cnt_regif_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cs_n,
    input  logic                    rd_n,
    input  logic                    wr_n,
    input  logic [1:0]              addr,
    inout  wire  [BYTE_W-1:0]       io_data,
    input  logic [NUM_CH*CNT_W-1:0] rdback,
    output logic [NUM_CH*CNT_W-1:0] ch_count
);

    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] CMD_ADDR = '1;

    logic                     wr_commit;
    logic                     rd_done;
    logic [ADDR_W-1:0]        rd_addr;
    logic                     cmd_commit;
    logic [1:0]               cmd_sel;
    acc_mode_e                cmd_mode;
    logic [BYTE_W-1:0]        wr_data;
    logic [NUM_CH*BYTE_W-1:0] ch_bytes;
    logic [BYTE_W-1:0]        mux_byte;
    logic                     pin_oe;

    assign wr_data    = io_data;
    assign cmd_commit = wr_commit && (addr == CMD_ADDR);
    assign cmd_sel    = wr_data[SEL_LSB +: 2];
    assign cmd_mode   = acc_mode_e'(wr_data[MODE_LSB +: 2]);

    cnt_bus_strobe #(
        .ADDR_W (ADDR_W)
    ) u_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .addr      (addr),
        .wr_commit (wr_commit),
        .rd_done   (rd_done),
        .rd_addr   (rd_addr)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        logic wr_hit;
        logic cw_hit;
        logic rd_hit;

        assign wr_hit = wr_commit && (addr == ADDR_W'(g));
        assign cw_hit = cmd_commit && (cmd_sel == 2'(g));
        assign rd_hit = rd_done && (rd_addr == ADDR_W'(g));

        cnt_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_data (wr_data),
            .wr_hit  (wr_hit),
            .cw_hit  (cw_hit),
            .cw_mode (cmd_mode),
            .rd_hit  (rd_hit),
            .rdback  (rdback[g*CNT_W +: CNT_W]),
            .count   (ch_count[g*CNT_W +: CNT_W]),
            .rd_byte (ch_bytes[g*BYTE_W +: BYTE_W])
        );
    end

    cnt_rd_mux #(
        .NUM_CH (NUM_CH),
        .BYTE_W (BYTE_W),
        .ADDR_W (ADDR_W)
    ) u_rd_mux (
        .addr     (addr),
        .ch_bytes (ch_bytes),
        .rd_byte  (mux_byte)
    );

    // Pin enable: only a selected read turns the drivers on
    assign pin_oe  = !cs_n && !rd_n;
    assign io_data = pin_oe ? mux_byte : {BYTE_W{1'bz}};

    // R2: the command address reads back as zero
    p_cmd_addr_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == CMD_ADDR) |-> (mux_byte == '0));

endmodule

// File: tb/tb_cnt_host_regif.sv
`timescale 1ns/1ps
module tb_cnt_host_regif;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [1:0]  addr = 2'b00;
    logic        tb_oe = 1'b0;
    logic [7:0]  tb_dq = 8'h00;
    wire  [7:0]  io_data;
    logic [47:0] rdback;
    logic [47:0] ch_count;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [1:0]  m_mode [3];
    logic        m_ptr  [3];
    logic [15:0] m_cnt  [3];
    logic [15:0] m_rdv  [3];
    logic [15:0] m_snap [3];
    logic        m_held [3];

    assign io_data = tb_oe ? tb_dq : 8'hzz;
    assign rdback  = {m_rdv[2], m_rdv[1], m_rdv[0]};

    always #4 clk = ~clk;

    cnt_host_regif dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .addr     (addr),
        .io_data  (io_data),
        .rdback   (rdback),
        .ch_count (ch_count)
    );

    task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [47:0] exp_counts();
        return {m_cnt[2], m_cnt[1], m_cnt[0]};
    endfunction

    function automatic logic [7:0] exp_read(input int ch);
        logic [15:0] s;
        if (ch > 2) return 8'h00;
        s = m_held[ch] ? m_snap[ch] : m_rdv[ch];
        case (m_mode[ch])
            2'b01:   return s[7:0];
            2'b10:   return s[15:8];
            default: return m_ptr[ch] ? s[15:8] : s[7:0];
        endcase
    endfunction

    // Reference update for a committed write
    task automatic model_write(input int a, input logic [7:0] d);
        int sel;
        if (a == 3) begin
            sel = int'(d[7:6]);
            if (sel != 3) begin
                m_ptr[sel] = 1'b0;
                if (d[5:4] == 2'b00) begin
                    if (!m_held[sel]) begin
                        m_held[sel] = 1'b1;
                        m_snap[sel] = m_rdv[sel];
                    end
                end else begin
                    m_mode[sel] = d[5:4];
                end
            end
        end else begin
            case (m_mode[a])
                2'b01: m_cnt[a][7:0]  = d;
                2'b10: m_cnt[a][15:8] = d;
                default: begin
                    if (m_ptr[a]) m_cnt[a][15:8] = d;
                    else          m_cnt[a][7:0]  = d;
                    m_ptr[a] = !m_ptr[a];
                end
            endcase
        end
    endtask

    // Reference update for a completed read
    task automatic model_read(input int a);
        if (a > 2) return;
        if (m_mode[a] == 2'b11) begin
            if (m_held[a] && m_ptr[a]) m_held[a] = 1'b0;
            m_ptr[a] = !m_ptr[a];
        end else if (m_held[a]) begin
            m_held[a] = 1'b0;
        end
    endtask

    // Write with strobes held for 'hold' clock cycles
    task automatic bus_write(input int a, input logic [7:0] d, input int hold, input bit sel);
        @(negedge clk);
        addr  = 2'(a);
        tb_dq = d;
        tb_oe = 1'b1;
        cs_n  = !sel;
        wr_n  = 1'b0;
        repeat (hold) @(negedge clk);
        wr_n  = 1'b1;
        cs_n  = 1'b1;
        tb_oe = 1'b0;
        if (sel) model_write(a, d);
    endtask

    task automatic bus_read(input int a, input string req);
        logic [7:0] got;
        @(negedge clk);
        addr = 2'(a);
        cs_n = 1'b0;
        rd_n = 1'b0;
        #2;
        got = io_data;
        check(req, {40'h0, got}, {40'h0, exp_read(a)});
        @(negedge clk);
        rd_n = 1'b1;
        cs_n = 1'b1;
        @(negedge clk);
        model_read(a);
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED_0C47);
        for (int i = 0; i < 3; i++) begin
            m_mode[i] = 2'b11; m_ptr[i] = 1'b0; m_cnt[i] = '0;
            m_snap[i] = '0; m_held[i] = 1'b0;
            m_rdv[i] = 16'h0A0B + 16'(i * 16'h1111);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state of counts and default two-byte read order
        check("R9 reset counts", ch_count, 48'h0);
        bus_read(0, "R9 reset low byte first");
        bus_read(0, "R9 reset then high byte");

        // R6 R7 R10: two-byte write into channel 1
        bus_write(1, 8'h34, 1, 1'b1);
        bus_write(1, 8'h12, 1, 1'b1);
        check("R10 channel 1 field", ch_count, exp_counts());
        check("R6 two-byte load", {32'h0, ch_count[31:16]}, 48'h1234);

        // R5 R6: low-only then high-only on channel 2
        bus_write(3, 8'h90, 1, 1'b1);
        bus_write(2, 8'h55, 1, 1'b1);
        bus_write(2, 8'h66, 1, 1'b1);
        check("R6 low-only mode", ch_count, exp_counts());
        bus_write(3, 8'hA0, 1, 1'b1);
        bus_write(2, 8'h77, 1, 1'b1);
        check("R5 high-only mode", {32'h0, ch_count[47:32]}, 48'h7766);

        // R3: write strobe with chip select high is ignored
        bus_write(0, 8'hEE, 1, 1'b0);
        check("R3 unselected write", ch_count, exp_counts());

        // R4: a long strobe commits once, pointer advances once
        bus_write(0, 8'hC3, 3, 1'b1);
        bus_write(0, 8'h3C, 1, 1'b1);
        check("R4 single commit", {32'h0, ch_count[15:0]}, 48'h3CC3);

        // R7: command clears the pointer mid-pair
        bus_write(0, 8'h11, 1, 1'b1);
        bus_write(3, 8'h30, 1, 1'b1);
        bus_write(0, 8'h22, 1, 1'b1);
        check("R7 pointer cleared", {32'h0, ch_count[15:0]}, 48'h3C22);

        // R8: snapshot survives a readback change until both bytes read
        @(negedge clk);
        m_rdv[1] = 16'hBEEF;
        bus_write(3, 8'h40, 1, 1'b1);
        @(negedge clk);
        m_rdv[1] = 16'h1111;
        bus_read(1, "R8 snapshot low");
        bus_read(1, "R8 snapshot high");
        bus_read(1, "R8 released live low");
        bus_read(1, "R8 released live high");

        // R2: command address reads zero
        bus_read(3, "R2 command address zero");

        // R5: selector 3 touches no channel
        bus_write(3, 8'hD0, 1, 1'b1);
        bus_write(1, 8'h5A, 1, 1'b1);
        check("R5 no-channel command", ch_count, exp_counts());

        // R1 R2 R6 R7 R8: constrained random mix against the model
        for (int n = 0; n < 400; n++) begin
            int op;
            int a;
            logic [7:0] d;
            op = int'($urandom_range(0, 9));
            a  = int'($urandom_range(0, 2));
            d  = 8'($urandom());
            if (op < 2) begin
                @(negedge clk);
                m_rdv[a] = 16'($urandom());
            end else if (op < 4) begin
                d[7:6] = 2'($urandom_range(0, 3));
                bus_write(3, d, 1, 1'b1);
            end else if (op < 7) begin
                bus_write(a, d, int'($urandom_range(1, 2)), 1'b1);
                check("R1 R6 random write", ch_count, exp_counts());
            end else begin
                bus_read(int'($urandom_range(0, 3)), "R2 R7 R8 random read");
            end
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule